// File: doc/BRIEF.md
# Pager Receiver Mode Controller

This block sequences a paging-code receiver through its four operating modes: switch-on, idle, preamble search and lock. The bit-level correlators upstream turn the incoming stream into single-cycle strobes (preamble pattern seen, sync codeword seen, sync window reached), and a bit-rate tick paces the timing. The controller decides the mode from these strobes, keeps track of where the receiver is inside a batch, and drives a power strobe that wakes the radio front end only when it has to listen.

A batch is one sync codeword followed by eight frames, each frame holding two 32-bit codewords. In lock mode, the receiver listens in the frame picked by a 3-bit frame setting, in the sync slot at the end of the batch, and for as long as a message is being received. Missed sync codewords are counted. Two misses in a row drop the receiver out of lock, unless a message is in progress. The fallback goes to preamble search instead of idle when a preamble pattern is seen at the second miss. A sync seen in the very first cycle after leaving lock puts the receiver straight back into lock.

Top module: `pager_mode_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `mode` reads 0 (switch-on), `rx_on` is 0 and `frame_no` is 0. Mode codes are 0 switch-on, 1 idle, 2 preamble, 3 lock.
- R2: In switch-on mode, the preamble, sync and rate-error inputs have no effect on `mode` until `id_done` has been seen once since reset.
- R3: After the ID is loaded, switch-on mode responds to its inputs in this priority order. A sync goes to lock. Otherwise a preamble goes to preamble mode. Otherwise a rate error, or 100 consecutive `bit_en` ticks with neither sync nor preamble, goes to idle.
- R4: In preamble mode, a sync goes to lock, and 100 `bit_en` ticks without a new preamble strobe go to idle. In idle mode, a preamble goes to preamble mode, and a sync is ignored except in the case covered by R9.
- R5: `rx_on` follows the state of the previous cycle. In lock mode it is high when `frame_sel` is 0, when `msg_active` is high, during the sync slot, or when the current frame index equals `frame_sel`; otherwise it is low. Outside lock it is 1 in idle and preamble mode and 0 in switch-on mode.
- R6: In lock mode, the bit position advances on each `bit_en` and wraps after 544 bits. `frame_no` is the position divided by 64 for positions 0 to 511, and reads 0 during the 32-bit sync slot.
- R7: In lock mode, a `sync_win` without `sync_det` counts as a miss, and any `sync_det` clears the count. The second consecutive miss, with `msg_active` low, goes to idle. If `pre_det` is high in that same cycle, it goes to preamble mode instead.
- R8: While `msg_active` is high, misses never take the controller out of lock. Sync detection carries on at every window, and once the message ends the next miss falls back.
- R9: A `sync_det` in the first cycle after leaving lock returns the controller to lock directly. One cycle later, in idle, it is ignored.
- R10: Every accepted sync resets the bit position to 0, so `frame_no` reads 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One pulse per received bit period |
| id_done | input | 1 | ID code load finished |
| rate_err | input | 1 | Bit-rate mismatch flag |
| pre_det | input | 1 | Preamble pattern strobe |
| sync_det | input | 1 | Sync codeword strobe |
| sync_win | input | 1 | Sync window strobe |
| msg_active | input | 1 | A message is being received |
| frame_sel | input | 3 | Own frame number; 0 keeps the receiver on |
| mode | output | 2 | Current mode code |
| rx_on | output | 1 | Receiver power strobe |
| frame_no | output | 3 | Current frame index inside the batch |

## Verification
The bench targets the miss-fallback corners. A design that counted misses without clearing them on a sync would drop lock after two misses that are not consecutive. One that ignored `msg_active` would cut a multi-batch message short. One that ignored `pre_det` at the second miss would fall to idle instead of preamble. It also hits the one-cycle re-lock window: a design with a wider window would re-lock from stale idle, and one with no window would leave the receiver idle. The frame-gated strobe is checked at every position of a full batch, which catches a wrong wrap point and an off-by-one frame boundary.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    M_SWON = 2'd0,
    M_IDLE = 2'd1,
    M_PRE  = 2'd2,
    M_LOCK = 2'd3
  } mode_t;
endpackage

// File: rtl/pmc_batch_timer.sv
module pmc_batch_timer #(
  parameter int CW_BITS      = 32,
  parameter int FRAMES       = 8,
  parameter int CW_PER_FRAME = 2,
  localparam int FRAME_BITS  = CW_BITS * CW_PER_FRAME,
  localparam int REGION      = FRAMES * FRAME_BITS,
  localparam int BATCH       = REGION + CW_BITS,
  localparam int PW          = $clog2(BATCH),
  localparam int FW          = $clog2(FRAMES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          bit_en,
  input  logic          align,
  output logic [FW-1:0] frame_no,
  output logic          in_sync_slot
);
  localparam logic [PW-1:0] LAST  = PW'(BATCH - 1);
  localparam logic [PW-1:0] SLOT0 = PW'(REGION);

  logic [PW-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (rst)                pos_q <= '0;
    else if (align)         pos_q <= '0;
    else if (run && bit_en) pos_q <= (pos_q == LAST) ? '0 : pos_q + 1'b1;
  end

  always_comb begin
    in_sync_slot = (pos_q >= SLOT0);
    frame_no     = in_sync_slot ? '0 : FW'(pos_q / PW'(FRAME_BITS));
  end

  assert_pos_range_R6: assert property (@(posedge clk) disable iff (rst)
    pos_q <= LAST);
  assert_align_R10: assert property (@(posedge clk) disable iff (rst)
    align |=> (pos_q == '0));
endmodule

// File: rtl/pmc_miss_tracker.sv
module pmc_miss_tracker (
  input  logic clk,
  input  logic rst,
  input  logic in_lock,
  input  logic sync_det,
  input  logic sync_win,
  output logic second_miss
);
  logic [1:0] miss_q;

  always_ff @(posedge clk) begin
    if (rst || !in_lock)            miss_q <= 2'd0;
    else if (sync_det)              miss_q <= 2'd0;
    else if (sync_win && miss_q != 2'd2) miss_q <= miss_q + 2'd1;
  end

  assign second_miss = in_lock && sync_win && !sync_det && (miss_q != 2'd0);

  assert_miss_sat_R7: assert property (@(posedge clk) disable iff (rst)
    miss_q != 2'd3);
  assert_miss_clear_R7: assert property (@(posedge clk) disable iff (rst)
    sync_det |=> (miss_q == 2'd0));
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
#(
  parameter int TIMEOUT_BITS = 100,
  parameter int FW           = 3,
  localparam int TW          = $clog2(TIMEOUT_BITS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_en,
  input  logic          id_done,
  input  logic          rate_err,
  input  logic          pre_det,
  input  logic          sync_det,
  input  logic          msg_active,
  input  logic          second_miss,
  input  logic          in_sync_slot,
  input  logic [FW-1:0] frame_no,
  input  logic [FW-1:0] frame_sel,
  output mode_t         mode_q,
  output logic          rx_on_q,
  output logic          align
);
  mode_t         mode_n;
  logic          id_loaded_q, just_left_q;
  logic [TW-1:0] tmo_q;
  logic          counting, tmo, lock_on;

  always_comb begin
    counting = (mode_q == M_SWON && id_loaded_q) || mode_q == M_PRE;
    tmo      = counting && bit_en && (tmo_q == TW'(TIMEOUT_BITS - 1));
    mode_n   = mode_q;
    unique case (mode_q)
      M_SWON: if (id_loaded_q) begin
        if (sync_det)             mode_n = M_LOCK;
        else if (pre_det)         mode_n = M_PRE;
        else if (rate_err || tmo) mode_n = M_IDLE;
      end
      M_IDLE: begin
        if (just_left_q && sync_det) mode_n = M_LOCK;
        else if (pre_det)            mode_n = M_PRE;
      end
      M_PRE: begin
        if (sync_det)            mode_n = M_LOCK;
        else if (tmo && !pre_det) mode_n = M_IDLE;
      end
      M_LOCK: if (second_miss && !msg_active)
        mode_n = pre_det ? M_PRE : M_IDLE;
      default: mode_n = M_SWON;
    endcase
    align   = sync_det && (mode_n == M_LOCK);
    lock_on = (frame_sel == '0) || msg_active || in_sync_slot || (frame_no == frame_sel);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= M_SWON;
      rx_on_q     <= 1'b0;
      id_loaded_q <= 1'b0;
      just_left_q <= 1'b0;
      tmo_q       <= '0;
    end else begin
      mode_q      <= mode_n;
      rx_on_q     <= (mode_q == M_LOCK) ? lock_on : (mode_q != M_SWON);
      just_left_q <= (mode_q == M_LOCK) && (mode_n != M_LOCK);
      if (mode_q == M_SWON && id_done) id_loaded_q <= 1'b1;
      if (mode_n != mode_q || pre_det || !counting) tmo_q <= '0;
      else if (bit_en)                              tmo_q <= tmo_q + 1'b1;
    end
  end

  assert_hold_swon_R2: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_SWON && !id_loaded_q) |=> (mode_q == M_SWON));
  assert_lock_entry_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_q != M_LOCK && !sync_det) |=> (mode_q != M_LOCK));
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_IDLE && !just_left_q && !pre_det) |=> (mode_q == M_IDLE));
  assert_fsel_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_LOCK && frame_sel == '0) |=> rx_on_q);
  assert_msg_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_LOCK && msg_active) |=> (mode_q == M_LOCK));
endmodule

// File: rtl/pager_mode_ctrl.sv
module pager_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int CW_BITS      = 32,
  parameter int FRAMES       = 8,
  parameter int CW_PER_FRAME = 2,
  parameter int TIMEOUT_BITS = 100,
  localparam int FW          = $clog2(FRAMES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_en,
  input  logic          id_done,
  input  logic          rate_err,
  input  logic          pre_det,
  input  logic          sync_det,
  input  logic          sync_win,
  input  logic          msg_active,
  input  logic [FW-1:0] frame_sel,
  output logic [1:0]    mode,
  output logic          rx_on,
  output logic [FW-1:0] frame_no
);
  mode_t mode_q;
  logic  align, second_miss, in_sync_slot, in_lock;

  assign in_lock = (mode_q == M_LOCK);
  assign mode    = mode_q;

  pmc_batch_timer #(
    .CW_BITS(CW_BITS), .FRAMES(FRAMES), .CW_PER_FRAME(CW_PER_FRAME)
  ) u_timer (
    .clk(clk), .rst(rst), .run(in_lock), .bit_en(bit_en), .align(align),
    .frame_no(frame_no), .in_sync_slot(in_sync_slot)
  );

  pmc_miss_tracker u_miss (
    .clk(clk), .rst(rst), .in_lock(in_lock), .sync_det(sync_det),
    .sync_win(sync_win), .second_miss(second_miss)
  );

  pmc_mode_fsm #(.TIMEOUT_BITS(TIMEOUT_BITS), .FW(FW)) u_fsm (
    .clk(clk), .rst(rst), .bit_en(bit_en), .id_done(id_done),
    .rate_err(rate_err), .pre_det(pre_det), .sync_det(sync_det),
    .msg_active(msg_active), .second_miss(second_miss),
    .in_sync_slot(in_sync_slot), .frame_no(frame_no), .frame_sel(frame_sel),
    .mode_q(mode_q), .rx_on_q(rx_on), .align(align)
  );
endmodule

// File: tb/sim_pager_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pager_mode_ctrl;
  localparam int TMO = 100, FB = 64, REGION = 512, BATCH = 544;

  logic clk = 1'b0, rst = 1'b1;
  logic bit_en = 0, id_done = 0, rate_err = 0, pre_det = 0, sync_det = 0;
  logic sync_win = 0, msg_active = 0;
  logic [2:0] frame_sel = 3'd0;
  logic [1:0] mode;
  logic rx_on;
  logic [2:0] frame_no;

  int checks = 0, errors = 0;
  int m_mode, m_pos, m_miss, m_t, m_rx;
  bit m_idl, m_jl;

  always #2.5 clk = ~clk;

  pager_mode_ctrl u0 (
    .clk(clk), .rst(rst), .bit_en(bit_en), .id_done(id_done),
    .rate_err(rate_err), .pre_det(pre_det), .sync_det(sync_det),
    .sync_win(sync_win), .msg_active(msg_active), .frame_sel(frame_sel),
    .mode(mode), .rx_on(rx_on), .frame_no(frame_no)
  );

  task automatic check(input string tg, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tg, what, act, exp, $time);
    end
  endtask

  function automatic int exp_frame(input int p);
    return (p < REGION) ? p / FB : 0;
  endfunction

  task automatic model_reset();
    m_mode = 0; m_pos = 0; m_miss = 0; m_t = 0; m_rx = 0; m_idl = 0; m_jl = 0;
  endtask

  task automatic model_step(input bit be, idd, re, pr, sy, sw, ms);
    int nm, nrx, npos, nmiss, nt;
    bit cnt, tmo, second;
    cnt    = (m_mode == 0 && m_idl) || m_mode == 2;
    tmo    = cnt && be && (m_t == TMO - 1);
    second = (m_mode == 3) && sw && !sy && (m_miss >= 1);
    nm = m_mode;
    case (m_mode)
      0: if (m_idl) begin
           if (sy) nm = 3; else if (pr) nm = 2; else if (re || tmo) nm = 1;
         end
      1: if (m_jl && sy) nm = 3; else if (pr) nm = 2;
      2: if (sy) nm = 3; else if (tmo && !pr) nm = 1;
      default: if (second && !ms) nm = pr ? 2 : 1;
    endcase
    if (m_mode == 3)
      nrx = (frame_sel == 0 || ms || m_pos >= REGION || (m_pos / FB) == frame_sel) ? 1 : 0;
    else
      nrx = (m_mode != 0) ? 1 : 0;
    if (sy && nm == 3) npos = 0;
    else if (m_mode == 3 && be) npos = (m_pos == BATCH - 1) ? 0 : m_pos + 1;
    else npos = m_pos;
    if (m_mode != 3 || sy) nmiss = 0;
    else if (sw) nmiss = (m_miss >= 2) ? 2 : m_miss + 1;
    else nmiss = m_miss;
    if (nm != m_mode || pr || !cnt) nt = 0;
    else if (be) nt = m_t + 1;
    else nt = m_t;
    if (m_mode == 0 && idd) m_idl = 1;
    m_jl = (m_mode == 3) && (nm != 3);
    m_mode = nm; m_rx = nrx; m_pos = npos; m_miss = nmiss; m_t = nt;
  endtask

  task automatic step(input bit be, idd, re, pr, sy, sw, ms, input string tg);
    bit_en = be; id_done = idd; rate_err = re; pre_det = pr;
    sync_det = sy; sync_win = sw; msg_active = ms;
    model_step(be, idd, re, pr, sy, sw, ms);
    @(posedge clk);
    @(negedge clk);
    check(tg, "mode", int'(mode), m_mode);
    check(tg, "rx_on", int'(rx_on), m_rx);
    check(tg, "frame_no", int'(frame_no), exp_frame(m_pos));
  endtask

  task automatic idle_cycles(input int n, input bit be, input bit ms, input string tg);
    for (int i = 0; i < n; i++) step(be, 0, 0, 0, 0, 0, ms, tg);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    bit_en = 0; id_done = 0; rate_err = 0; pre_det = 0;
    sync_det = 0; sync_win = 0; msg_active = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    model_reset();
    check("R1", "mode in reset", int'(mode), 0);
    check("R1", "rx_on in reset", int'(rx_on), 0);
    check("R1", "frame_no in reset", int'(frame_no), 0);
    rst = 1'b0;
  endtask

  task automatic lock_up();
    do_reset();
    step(0, 1, 0, 0, 0, 0, 0, "R3");
    step(0, 0, 0, 0, 1, 0, 0, "R3");
    check("R3", "sync from switch-on", int'(mode), 3);
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned r;
    bit be, idd, re, pr, sy, sw, ms;
    model_reset();
    @(negedge clk);
    do_reset();
    step(0, 0, 0, 0, 0, 0, 0, "R1");
    check("R1", "mode after reset", int'(mode), 0);

    // R2: strobes before the ID load are ignored
    step(0, 0, 0, 1, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 1, 0, 0, "R2");
    step(1, 0, 1, 0, 0, 0, 0, "R2");
    check("R2", "still switch-on", int'(mode), 0);

    // R3: priority and timeout out of switch-on
    lock_up();
    do_reset();
    step(0, 1, 0, 0, 0, 0, 0, "R3");
    step(0, 0, 1, 1, 0, 0, 0, "R3");
    check("R3", "preamble beats rate error", int'(mode), 2);
    do_reset();
    step(0, 1, 0, 0, 0, 0, 0, "R3");
    step(0, 0, 1, 0, 0, 0, 0, "R3");
    check("R3", "rate error to idle", int'(mode), 1);
    do_reset();
    step(0, 1, 0, 0, 0, 0, 0, "R3");
    idle_cycles(TMO - 1, 1, 0, "R3");
    check("R3", "before timeout", int'(mode), 0);
    step(1, 0, 0, 0, 0, 0, 0, "R3");
    check("R3", "timeout to idle", int'(mode), 1);

    // R4: preamble timeout, idle ignores sync
    do_reset();
    step(0, 1, 0, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 1, 0, 0, 0, "R4");
    idle_cycles(50, 1, 0, "R4");
    step(1, 0, 0, 1, 0, 0, 0, "R4");
    idle_cycles(TMO - 1, 1, 0, "R4");
    check("R4", "preamble retriggered", int'(mode), 2);
    step(1, 0, 0, 0, 0, 0, 0, "R4");
    check("R4", "preamble timeout", int'(mode), 1);
    step(0, 0, 0, 0, 1, 0, 0, "R4");
    check("R4", "idle ignores sync", int'(mode), 1);
    step(0, 0, 0, 1, 0, 0, 0, "R4");
    check("R4", "idle to preamble", int'(mode), 2);

    // R5/R6: full batch with frame 3 selected
    frame_sel = 3'd3;
    lock_up();
    idle_cycles(200, 1, 0, "R5");
    check("R6", "frame at pos 200", int'(frame_no), 3);
    check("R5", "strobe in own frame", int'(rx_on), 1);
    idle_cycles(60, 1, 0, "R5");
    check("R5", "strobe off in frame 4", int'(rx_on), 0);
    idle_cycles(260, 1, 1, "R5");
    idle_cycles(BATCH + 40 - 520, 1, 0, "R6");
    check("R6", "wrapped frame", int'(frame_no), 0);

    // R10: realign mid batch
    idle_cycles(150, 1, 0, "R10");
    step(1, 0, 0, 0, 1, 1, 0, "R10");
    check("R10", "frame after realign", int'(frame_no), 0);

    // R7: consecutive misses, cleared misses, preamble on second miss
    step(0, 0, 0, 0, 0, 1, 0, "R7");
    step(0, 0, 0, 0, 0, 1, 0, "R7");
    check("R7", "two misses to idle", int'(mode), 1);
    lock_up();
    step(0, 0, 0, 0, 0, 1, 0, "R7");
    step(0, 0, 0, 0, 1, 1, 0, "R7");
    step(0, 0, 0, 0, 0, 1, 0, "R7");
    check("R7", "miss after clear stays", int'(mode), 3);
    step(0, 0, 0, 1, 0, 1, 0, "R7");
    check("R7", "second miss with preamble", int'(mode), 2);

    // R8: message holds lock
    lock_up();
    step(0, 0, 0, 0, 0, 1, 1, "R8");
    step(0, 0, 0, 0, 0, 1, 1, "R8");
    step(0, 0, 0, 0, 0, 1, 1, "R8");
    check("R8", "message keeps lock", int'(mode), 3);
    step(0, 0, 0, 0, 0, 1, 0, "R8");
    check("R8", "message ended, miss falls", int'(mode), 1);

    // R9: one-cycle re-lock window
    step(0, 0, 0, 0, 1, 0, 0, "R9");
    check("R9", "relock right after leaving", int'(mode), 3);
    step(0, 0, 0, 0, 0, 1, 0, "R9");
    step(0, 0, 0, 0, 0, 1, 0, "R9");
    step(0, 0, 0, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 1, 0, 0, "R9");
    check("R9", "late sync ignored", int'(mode), 1);

    // mixed random stimulus against the model
    r = $urandom(32'd20240611);
    for (int i = 0; i < 30000; i++) begin
      if (i % 5000 == 0) do_reset();
      r  = $urandom % 1000;
      be = ($urandom % 10) < 7;
      idd = ($urandom % 100) < 5;
      re = ($urandom % 200) == 0;
      pr = ($urandom % 100) < 3;
      sy = ($urandom % 100) < 2;
      sw = ($urandom % 100) < 4;
      if (r < 10) msg_active = ~msg_active;
      if (r > 995) frame_sel = 3'($urandom % 8);
      ms = msg_active;
      step(be, idd, re, pr, sy, sw, ms, "R7");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule